// File: doc/BRIEF.md
# Byte-Lane Interrupt Source Controller

This block collects a set of interrupt source lines and keeps one pending bit per source. It presents one output level per source to a downstream controller. Software reaches a bank of 64-bit registers through a request/response port that accepts 1-, 2-, 4- and 8-byte accesses. A narrow write touches only its own byte lanes. A narrow read returns the addressed lanes shifted down to bit 0.

Each source is either edge-triggered or level-triggered and has its own polarity. An edge-triggered source latches pending on a rising edge and holds it until software clears it. A level-triggered source's pending bit follows the line. A source is forwarded only while pending and unmasked. A change of mask takes effect on the outputs at once, with no re-trigger needed. The bank also holds a message-enable word, a per-source 8-bit vector table and an identification word. Route and auto-control locations are fixed and read-only.

Request port rules: a request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a response is waiting, so only one access is outstanding at a time. The response appears on the cycle after acceptance. It stays stable until `rsp_ready` is seen high.

Top module: `pic_lane_ctrl`

Register offsets (byte addresses, 8-byte words). The size code on `req_size` is the log2 of the access length (0 = 1 byte, 3 = 8 bytes).

| Offset | Register | Access |
|---|---|---|
| 0x000 | identification | read-only |
| 0x020 | mask (bit n masks source n) | read/write |
| 0x040 | message enable | read/write |
| 0x060 | trigger select (1 = edge, 0 = level) | read/write |
| 0x080 | clear | write-only, reads 0 |
| 0x0A0, 0x0C0 | auto-control 0/1 | reads 0, writes ignored |
| 0x100 + NSRC bytes | route table | every byte reads 0x01, writes ignored |
| 0x200 + NSRC bytes | vector table (byte n is source n) | read/write |
| 0x300 | pending | read-only |
| 0x320 | in-service (forwarded levels) | read-only |
| 0x3E0 | polarity (1 = inverted) | read/write |

## Requirements
- R1: An access whose address is not a multiple of its length is answered with `rsp_err`=1 and read data 0, and it changes no register.
- R2: A write of length L at byte offset k within a word replaces only bytes k..k+L-1 of that word with the low L bytes of `req_wdata`. The other bytes keep their values.
- R3: A read of length L at byte offset k returns the word shifted right by 8*k bits, keeping only the low 8*L bits. The upper bits of `rsp_rdata` are zero.
- R4: After reset the mask word is all ones, `irq_out` is 0, the trigger-select, polarity, message-enable and pending words are 0, and vector-table byte n holds n.
- R5: A mask write that unmasks a pending source raises its `irq_out` bit on the edge that accepts the write. A write that masks a source lowers its bit on that same edge. A masked source's `irq_out` bit is never 1.
- R6: A write to the clear word clears only the pending bits that are set, edge-triggered and written as 1, and lowers the matching `irq_out` bits. Level-triggered bits and bits written as 0 are unaffected.
- R7: The identification word reads as: controller ID parameter in bits 31:24, version parameter in bits 39:32, and NSRC-1 in bits 55:48. All other bits are 0, and writes are ignored.
- R8: Every byte of the route table reads 0x01, and both auto-control words read 0. Writes to these locations are accepted without error and leave the read values unchanged.
- R9: For an edge-triggered source, a 0-to-1 change of (input XOR polarity) sets its pending bit. The bit stays set while the input returns low. It is visible in the pending word one edge after the input was sampled.
- R10: For a level-triggered source, the pending bit equals the input XOR the polarity bit, one edge after sampling.
- R11: An access to an offset not listed in the register map is answered with `rsp_err`=1 and read data 0.
- R12: While a response is waiting and `rsp_ready` is low, `rsp_valid`, `rsp_err` and `rsp_rdata` hold their values and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | access request present |
| req_ready | output | 1 | request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | byte address |
| req_size | input | 2 | log2 of access length in bytes |
| req_wdata | input | 64 | write data, low bytes used |
| rsp_valid | output | 1 | response present |
| rsp_ready | input | 1 | response taken |
| rsp_err | output | 1 | access rejected |
| rsp_rdata | output | 64 | read data, low bytes valid |
| src_in | input | NSRC | interrupt source lines |
| irq_out | output | NSRC | per-source forwarded levels |

## Verification
The bench uses the default parameters: 32 sources, a 10-bit address, controller ID 0x07 and version 0x01. With 32 sources the live mask, trigger and polarity bits fill only the low half of each word. The upper halves are still plain storage, so byte-lane merges that cross the 4-byte boundary are checked against a model. The vector table spans four words, so randomly placed narrow accesses cover every word index and every lane position for each size.

// File: rtl/pic_lane_pkg.sv
package pic_lane_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_MASK, SEL_MSGEN, SEL_EDGE, SEL_POL, SEL_CLR,
    SEL_AUTO, SEL_ROUTE, SEL_VEC, SEL_IRR, SEL_ISR
  } reg_sel_e;

  localparam int OFS_ID    = 'h000;
  localparam int OFS_MASK  = 'h020;
  localparam int OFS_MSGEN = 'h040;
  localparam int OFS_EDGE  = 'h060;
  localparam int OFS_CLR   = 'h080;
  localparam int OFS_AUTO0 = 'h0A0;
  localparam int OFS_AUTO1 = 'h0C0;
  localparam int OFS_ROUTE = 'h100;
  localparam int OFS_VEC   = 'h200;
  localparam int OFS_IRR   = 'h300;
  localparam int OFS_ISR   = 'h320;
  localparam int OFS_POL   = 'h3E0;

  function automatic logic [63:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/pic_lane_decode.sv
module pic_lane_decode
  import pic_lane_pkg::*;
#(
  parameter int AW   = 10,
  parameter int NSRC = 32,
  parameter int IDXW = 2
) (
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      size,
  input  logic [63:0]     wdata,
  output reg_sel_e        sel,
  output logic            misal,
  output logic [2:0]      boff,
  output logic [63:0]     lmask,
  output logic [63:0]     wmask_sh,
  output logic [63:0]     wdata_sh,
  output logic [IDXW-1:0] vidx
);
  logic [AW-1:0] waddr;
  logic [AW-1:0] vrel;
  logic [2:0]    align_bits;
  int            wa;

  always_comb begin
    waddr      = {addr[AW-1:3], 3'b000};
    wa         = int'(waddr);
    boff       = addr[2:0];
    align_bits = 3'((4'd1 << size) - 4'd1);
    misal      = |(addr[2:0] & align_bits);
    lmask      = lane_mask(size);
    wmask_sh   = lmask << {boff, 3'b000};
    wdata_sh   = (wdata & lmask) << {boff, 3'b000};
    vrel       = waddr - AW'(OFS_VEC);
    vidx       = vrel[3 +: IDXW];
    if      (wa == OFS_ID)    sel = SEL_ID;
    else if (wa == OFS_MASK)  sel = SEL_MASK;
    else if (wa == OFS_MSGEN) sel = SEL_MSGEN;
    else if (wa == OFS_EDGE)  sel = SEL_EDGE;
    else if (wa == OFS_POL)   sel = SEL_POL;
    else if (wa == OFS_CLR)   sel = SEL_CLR;
    else if (wa == OFS_AUTO0 || wa == OFS_AUTO1) sel = SEL_AUTO;
    else if (wa >= OFS_ROUTE && wa < OFS_ROUTE + NSRC) sel = SEL_ROUTE;
    else if (wa >= OFS_VEC && wa < OFS_VEC + NSRC)     sel = SEL_VEC;
    else if (wa == OFS_IRR)   sel = SEL_IRR;
    else if (wa == OFS_ISR)   sel = SEL_ISR;
    else                      sel = SEL_NONE;
  end
endmodule

// File: rtl/pic_lane_vectab.sv
module pic_lane_vectab #(
  parameter int NSRC  = 32,
  parameter int NWORD = NSRC / 8,
  parameter int IDXW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [63:0]     wmask,
  input  logic [63:0]     wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [63:0]     rword
);
  logic [7:0]  entry_q [NSRC];
  logic [63:0] words   [NWORD];

  for (genvar e = 0; e < NSRC; e++) begin : g_entry
    localparam int W = e / 8;
    localparam int B = e % 8;
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q[e] <= 8'(e);
      else if (we && int'(widx) == W && wmask[B*8])
        entry_q[e] <= wdata[B*8 +: 8];
    end
    assign words[W][B*8 +: 8] = entry_q[e];
  end

  always_comb begin
    rword = '0;
    for (int w = 0; w < NWORD; w++)
      if (int'(ridx) == w) rword = words[w];
  end
endmodule

// File: rtl/pic_lane_srctrack.sv
module pic_lane_srctrack #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] edge_cfg,
  input  logic [NSRC-1:0] pol_cfg,
  input  logic [NSRC-1:0] mask_nxt,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] irr_o,
  output logic [NSRC-1:0] fwd_o
);
  logic [NSRC-1:0] lvl, lvl_q, rise, irr_d, fwd_d;

  always_comb begin
    lvl   = src_in ^ pol_cfg;
    rise  = lvl & ~lvl_q;
    irr_d = (edge_cfg & ((irr_o & ~clr_bits) | rise)) | (~edge_cfg & lvl);
    fwd_d = irr_d & ~mask_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      irr_o <= '0;
      fwd_o <= '0;
    end else begin
      lvl_q <= lvl;
      irr_o <= irr_d;
      fwd_o <= fwd_d;
    end
  end

  // R6 / R9: a latched edge bit survives unless it was cleared
  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irr_o & edge_cfg & ~clr_bits)) & ~irr_o) == '0);

  // R5: only pending sources are forwarded
  p_fwd_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_o & ~irr_o) == '0);
endmodule

// File: rtl/pic_lane_ctrl.sv
module pic_lane_ctrl
  import pic_lane_pkg::*;
#(
  parameter int         AW      = 10,
  parameter int         NSRC    = 32,
  parameter logic [7:0] CTRL_ID = 8'h07,
  parameter logic [7:0] VERSION = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic [63:0]     req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_err,
  output logic [63:0]     rsp_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic [NSRC-1:0] irq_out
);
  localparam int NWORD = NSRC / 8;
  localparam int IDXW  = (NWORD > 1) ? $clog2(NWORD) : 1;

  reg_sel_e        sel;
  logic            misal, err, acc, wr_ok;
  logic [2:0]      boff;
  logic [63:0]     lmask, wmask_sh, wdata_sh;
  logic [IDXW-1:0] vidx;
  logic [63:0]     mask_q, msgen_q, edge_q, pol_q, mask_d;
  logic [63:0]     vec_word, rd_word, rd_val, id_word;
  logic [NSRC-1:0] irr, clr_bits;

  pic_lane_decode #(.AW(AW), .NSRC(NSRC), .IDXW(IDXW)) u_dec (
    .addr(req_addr), .size(req_size), .wdata(req_wdata), .sel(sel),
    .misal(misal), .boff(boff), .lmask(lmask), .wmask_sh(wmask_sh),
    .wdata_sh(wdata_sh), .vidx(vidx)
  );

  assign req_ready = ~rsp_valid;
  assign acc       = req_valid & req_ready;
  assign err       = misal | (sel == SEL_NONE);
  assign wr_ok     = acc & req_write & ~err;
  assign id_word   = {8'h00, 8'(NSRC - 1), 8'h00, VERSION, CTRL_ID, 24'h000000};

  always_comb begin
    mask_d = mask_q;
    if (wr_ok && sel == SEL_MASK) mask_d = (mask_q & ~wmask_sh) | wdata_sh;
    clr_bits = (wr_ok && sel == SEL_CLR) ? wdata_sh[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      msgen_q <= '0;
      edge_q  <= '0;
      pol_q   <= '0;
    end else begin
      mask_q <= mask_d;
      if (wr_ok && sel == SEL_MSGEN) msgen_q <= (msgen_q & ~wmask_sh) | wdata_sh;
      if (wr_ok && sel == SEL_EDGE)  edge_q  <= (edge_q  & ~wmask_sh) | wdata_sh;
      if (wr_ok && sel == SEL_POL)   pol_q   <= (pol_q   & ~wmask_sh) | wdata_sh;
    end
  end

  pic_lane_vectab #(.NSRC(NSRC), .NWORD(NWORD), .IDXW(IDXW)) u_vec (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && sel == SEL_VEC), .widx(vidx),
    .wmask(wmask_sh), .wdata(wdata_sh), .ridx(vidx), .rword(vec_word)
  );

  pic_lane_srctrack #(.NSRC(NSRC)) u_src (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_cfg(edge_q[NSRC-1:0]),
    .pol_cfg(pol_q[NSRC-1:0]), .mask_nxt(mask_d[NSRC-1:0]),
    .clr_bits(clr_bits), .irr_o(irr), .fwd_o(irq_out)
  );

  always_comb begin
    case (sel)
      SEL_ID:    rd_word = id_word;
      SEL_MASK:  rd_word = mask_q;
      SEL_MSGEN: rd_word = msgen_q;
      SEL_EDGE:  rd_word = edge_q;
      SEL_POL:   rd_word = pol_q;
      SEL_ROUTE: rd_word = {8{8'h01}};
      SEL_VEC:   rd_word = vec_word;
      SEL_IRR:   rd_word = 64'(irr);
      SEL_ISR:   rd_word = 64'(irq_out);
      default:   rd_word = '0;
    endcase
    rd_val = err ? '0 : ((rd_word >> {boff, 3'b000}) & lmask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_err   <= err;
      rsp_rdata <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: a waiting response is held
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R11 / R1: rejected accesses carry zero data
  p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  // R1: a misaligned access leaves configuration untouched
  p_misalign_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && misal) |=> ($stable(mask_q) && $stable(edge_q) && $stable(pol_q) && $stable(msgen_q)));

  // R5: masked sources are never forwarded
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & mask_q[NSRC-1:0]) == '0);
endmodule

// File: tb/pic_lane_ctrl_tb.sv
module pic_lane_ctrl_tb;
  localparam int AW = 10;
  localparam int NSRC = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0]   req_addr = '0;
  logic [1:0]      req_size = '0;
  logic [63:0]     req_wdata = '0;
  logic            req_ready, rsp_valid, rsp_err;
  logic [63:0]     rsp_rdata;
  logic [NSRC-1:0] src_in = '0;
  logic [NSRC-1:0] irq_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pic_lane_ctrl #(.AW(AW), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .src_in(src_in), .irq_out(irq_out)
  );

  function automatic logic [63:0] f_lane(input logic [1:0] sz);
    return (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic logic [63:0] f_merge(input logic [63:0] old, input int off,
                                          input logic [1:0] sz, input logic [63:0] wd);
    logic [63:0] lm = f_lane(sz);
    return (old & ~(lm << (8 * off))) | ((wd & lm) << (8 * off));
  endfunction

  function automatic logic [63:0] f_read(input logic [63:0] w, input int off, input logic [1:0] sz);
    return (w >> (8 * off)) & f_lane(sz);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input int a, input logic [1:0] sz, input logic [63:0] wd,
                     output logic [63:0] rd, output bit er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, m_msgen, m_vec[4];
    bit er;
    void'($urandom(32'd20240607));
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 8; b++) m_vec[w][b*8 +: 8] = 8'(w * 8 + b);
    m_msgen = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset values
    chk(irq_out == '0, "R4 irq_out", 64'(irq_out), 0);
    acc(0, 'h020, 3, 0, rd, er); chk(rd == '1 && !er, "R4 mask reset", rd, '1);
    acc(0, 'h060, 3, 0, rd, er); chk(rd == '0, "R4 edge reset", rd, 0);
    acc(0, 'h208, 3, 0, rd, er); chk(rd == 64'h0F0E0D0C0B0A0908, "R4 vector reset", rd, 64'h0F0E0D0C0B0A0908);

    // R7: identification, also ignoring a write
    acc(1, 'h000, 3, '1, rd, er);
    acc(0, 'h000, 3, 0, rd, er); chk(rd == 64'h001F000107000000, "R7 id word", rd, 64'h001F000107000000);
    acc(0, 'h003, 0, 0, rd, er); chk(rd == 64'h07, "R7 id byte", rd, 64'h07);

    // R8: route and auto-control
    acc(1, 'h100, 3, 0, rd, er);
    acc(0, 'h100, 3, 0, rd, er); chk(rd == 64'h0101010101010101, "R8 route word", rd, 64'h0101010101010101);
    acc(0, 'h11B, 0, 0, rd, er); chk(rd == 64'h01, "R8 route byte", rd, 64'h01);
    acc(1, 'h0A0, 3, '1, rd, er); chk(!er, "R8 auto write ok", 64'(er), 0);
    acc(0, 'h0A0, 3, 0, rd, er); chk(rd == 0, "R8 auto0 read", rd, 0);
    acc(0, 'h0C4, 2, 0, rd, er); chk(rd == 0, "R8 auto1 read", rd, 0);

    // R2 / R3: random byte-lane accesses on pure storage words
    for (int i = 0; i < 300; i++) begin
      int tgt = int'($urandom % 2);
      int w = int'($urandom % 4);
      logic [1:0] sz = 2'($urandom % 4);
      int off = int'($urandom % 8) & ~((1 << sz) - 1);
      bit wr = 1'($urandom % 2);
      logic [63:0] wd = {$urandom, $urandom};
      int base = (tgt == 0) ? 'h040 : ('h200 + w * 8);
      logic [63:0] cur = (tgt == 0) ? m_msgen : m_vec[w];
      acc(wr, base + off, sz, wd, rd, er);
      if (wr) begin
        if (tgt == 0) m_msgen = f_merge(cur, off, sz, wd);
        else m_vec[w] = f_merge(cur, off, sz, wd);
        chk(!er, "R2 write accepted", 64'(er), 0);
      end else begin
        chk(rd == f_read(cur, off, sz) && !er, "R3 narrow read", rd, f_read(cur, off, sz));
      end
    end
    acc(0, 'h040, 3, 0, rd, er); chk(rd == m_msgen, "R2 msgen full", rd, m_msgen);
    acc(0, 'h218, 3, 0, rd, er); chk(rd == m_vec[3], "R2 vector word 3", rd, m_vec[3]);

    // R1: misaligned write rejected, mask unchanged
    acc(1, 'h022, 2, 0, rd, er); chk(er && rd == 0, "R1 misaligned error", {63'd0, er}, 1);
    acc(0, 'h020, 3, 0, rd, er); chk(rd == '1, "R1 mask unchanged", rd, '1);
    acc(0, 'h045, 1, 0, rd, er); chk(er && rd == 0, "R1 misaligned read", rd, 0);

    // R11: unmapped offset
    acc(0, 'h1F0, 3, 0, rd, er); chk(er && rd == 0, "R11 unmapped read", {63'd0, er}, 1);
    acc(1, 'h3A0, 3, '1, rd, er); chk(er, "R11 unmapped write", {63'd0, er}, 1);

    // R10: level source follows input, masked so no output
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk);
    acc(0, 'h300, 2, 0, rd, er); chk(rd == 64'h8, "R10 level pending", rd, 64'h8);
    chk(irq_out == '0, "R5 masked quiet", 64'(irq_out), 0);

    // R5: unmask bit 3 with a 4-byte write, then re-mask with a byte write
    acc(1, 'h020, 2, 64'hFFFFFFF7, rd, er);
    chk(irq_out == 32'h8, "R5 unmask forwards", 64'(irq_out), 64'h8);
    acc(0, 'h320, 3, 0, rd, er); chk(rd == 64'h8, "R5 in-service read", rd, 64'h8);
    acc(0, 'h020, 3, 0, rd, er); chk(rd == 64'hFFFFFFFFFFFFFFF7, "R2 mask merged", rd, 64'hFFFFFFFFFFFFFFF7);
    acc(1, 'h020, 0, 64'hFF, rd, er);
    chk(irq_out == '0, "R5 mask withdraws", 64'(irq_out), 0);

    // R10: polarity inverts a low input
    acc(1, 'h3E0, 0, 64'h20, rd, er);
    @(negedge clk);
    acc(0, 'h300, 0, 0, rd, er); chk(rd == 64'h28, "R10 polarity", rd, 64'h28);
    @(negedge clk); src_in[3] = 1'b0;
    @(negedge clk);
    acc(0, 'h300, 0, 0, rd, er); chk(rd == 64'h20, "R10 level follows low", rd, 64'h20);

    // R9: edge source 8 latches a one-cycle pulse
    acc(1, 'h061, 0, 64'h03, rd, er);
    acc(1, 'h021, 0, 64'hFE, rd, er);
    @(negedge clk); src_in[8] = 1'b1;
    @(negedge clk); src_in[8] = 1'b0;
    repeat (2) @(negedge clk);
    acc(0, 'h301, 0, 0, rd, er); chk(rd == 64'h01, "R9 edge latched", rd, 64'h01);
    chk(irq_out == 32'h100, "R9 edge forwarded", 64'(irq_out), 64'h100);

    // R6: clear ignores level bit 5, zero bits, and non-pending edge bit 9
    acc(1, 'h080, 3, 64'h220, rd, er);
    acc(0, 'h300, 2, 0, rd, er); chk(rd == 64'h120, "R6 clear no effect", rd, 64'h120);
    acc(1, 'h081, 0, 64'h01, rd, er);
    chk(irq_out == '0, "R6 clear drops output", 64'(irq_out), 0);
    acc(0, 'h300, 2, 0, rd, er); chk(rd == 64'h20, "R6 clear edge bit", rd, 64'h20);
    acc(0, 'h080, 3, 0, rd, er); chk(rd == 0 && !er, "R6 clear reads zero", rd, 0);

    // R12: response held while rsp_ready is low
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'('h000); req_size = 2'd3;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    rd = rsp_rdata;
    repeat (2) @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_rdata == rd, "R12 hold", rsp_rdata, rd);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R12 release", {63'd0, rsp_valid}, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule